// File: doc/BRIEF.md
# Load-Reserved Store-Conditional Monitor

This block watches the request stream into a memory and keeps a small table of address reservations for the execution contexts that issue load-locked reads. On a store-conditional it decides whether the store may go ahead, and on every store, plain or conditional, it cancels any reservation that the store's address conflicts with. The memory array is not part of the block. The memory's write path uses the write-permit output to decide whether to commit a store. The conditional result goes back to the requester.

Addresses are reduced to an 8-byte reservation granule before they are stored or compared. Each context owns at most one table entry. All table changes take effect at the clock edge that accepts the request. The response outputs are registered and appear one cycle later, qualified by a response-valid strobe. If a new reservation finds the table full, it is dropped and an overflow strobe is raised.

Top module: `resv_monitor`

## Requirements
- R1: After reset every table entry is invalid and all response outputs (rspValid, writePermit, condResult, overflow) are 0.
- R2: A request is decoded from reqWrite, reqRead and reqLocked. reqWrite=1 is a store, and a write has priority over reqRead. reqWrite=0 with reqRead=1 is a load. reqLocked=1 marks the store or load as conditional or locked. A load-locked from a context with no entry allocates an entry. A following store-conditional from that context to that granule returns condResult=1 and writePermit=1.
- R3: Address bits [2:0] are ignored for both storing and comparing. An access anywhere in the same 8-byte granule matches, and an access to the next granule does not.
- R4: A store-conditional succeeds only when an entry matches both its granule and its own context ID. A reservation held by another context on that granule does not make it succeed.
- R5: A plain store removes every entry on its granule, whichever context owns it.
- R6: A store-conditional, successful or not, also removes every entry on its granule from all contexts.
- R7: A context holds at most one reservation. A new load-locked from a context that already has an entry moves that entry to the new granule.
- R8: A plain store always returns writePermit=1 and condResult=0.
- R9: A failed store-conditional returns writePermit=0 and condResult=0.
- R10: A load-locked from a context with no entry, arriving when all entries are valid, allocates nothing and pulses overflow for exactly one cycle. A load-locked from a context that already has an entry never overflows.
- R11: rspValid is 1 exactly one cycle after each accepted request. A plain load (reqLocked=0) returns all other outputs 0 and leaves the table unchanged.
- R12: Several contexts may hold reservations on the same granule at once. Each such reservation stays usable until a store reaches that granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqRead | input | 1 | Request is a load |
| reqWrite | input | 1 | Request is a store (has priority over reqRead) |
| reqLocked | input | 1 | Load-locked or store-conditional qualifier |
| reqAddr | input | ADDR_W (32) | Byte address |
| reqCtx | input | CTX_W (4) | Requesting context ID |
| rspValid | output | 1 | Response for the previous cycle's request |
| writePermit | output | 1 | Store may be committed to memory |
| condResult | output | 1 | Store-conditional result, 1 = success |
| overflow | output | 1 | Load-locked dropped because the table was full |

## Verification
The bench targets shared granules. When two contexts reserve the same address, a design that removed only the writer's entry would let a stale store-conditional succeed after another context's store. A design that matched on address alone would let one context succeed on another's reservation. The bench also re-issues load-locked from the same context: a design that allocated a second entry instead of moving the old one would let a conditional store to the old address succeed. Table-full handling is tested with a load-locked from a new context and with one from a context that already holds an entry. A design that flagged overflow for the second, or that overwrote a live entry for the first, fails the checks.

// File: rtl/resv_pkg.sv
package resv_pkg;
  // Table update strobes from the control to the datapath.
  typedef struct packed {
    logic llUpdate;   // move the requester's existing entry to the new granule
    logic llAlloc;    // allocate the first free entry for the requester
    logic clearAddr;  // invalidate all entries on the request granule
  } resvStrobes_t;
endpackage

// File: rtl/resv_table.sv
module resv_table
  import resv_pkg::*;
#(
  parameter int TAG_W   = 29,
  parameter int CTX_W   = 4,
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  resvStrobes_t       strobes,
  input  logic [TAG_W-1:0]   reqTag,
  input  logic [CTX_W-1:0]   reqCtx,
  output logic [ENTRIES-1:0] ctxHit,
  output logic [ENTRIES-1:0] tagHit,
  output logic               tableFull
);
  logic [ENTRIES-1:0] entValid;
  logic [TAG_W-1:0]   entTag [ENTRIES];
  logic [CTX_W-1:0]   entCtx [ENTRIES];
  logic [ENTRIES-1:0] allocSel;

  // One-hot select of the lowest free entry.
  always_comb begin
    allocSel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) allocSel = ENTRIES'(1) << i;
    end
  end

  assign tableFull = &entValid;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
      assign ctxHit[g] = entValid[g] && (entCtx[g] == reqCtx);
      assign tagHit[g] = entValid[g] && (entTag[g] == reqTag);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          entValid[g] <= 1'b0;
          entTag[g]   <= '0;
          entCtx[g]   <= '0;
        end else if (strobes.clearAddr) begin
          if (tagHit[g]) entValid[g] <= 1'b0;
        end else if (strobes.llUpdate) begin
          if (ctxHit[g]) entTag[g] <= reqTag;
        end else if (strobes.llAlloc && allocSel[g]) begin
          entValid[g] <= 1'b1;
          entTag[g]   <= reqTag;
          entCtx[g]   <= reqCtx;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqRead,
  input  logic               reqWrite,
  input  logic               reqLocked,
  input  logic [ENTRIES-1:0] ctxHit,
  input  logic [ENTRIES-1:0] tagHit,
  input  logic               tableFull,
  output resvStrobes_t       strobes,
  output logic               rspValid,
  output logic               writePermit,
  output logic               condResult,
  output logic               overflow
);
  logic isStore, isLoadLocked, haveEntry, ownMatch, condOk, dropLl;

  assign isStore      = reqValid && reqWrite;
  assign isLoadLocked = reqValid && !reqWrite && reqRead && reqLocked;
  assign haveEntry    = |ctxHit;
  assign ownMatch     = |(ctxHit & tagHit);
  assign condOk       = isStore && reqLocked && ownMatch;
  assign dropLl       = isLoadLocked && !haveEntry && tableFull;

  always_comb begin
    strobes           = '0;
    strobes.clearAddr = isStore;
    strobes.llUpdate  = isLoadLocked && haveEntry;
    strobes.llAlloc   = isLoadLocked && !haveEntry && !tableFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      writePermit <= 1'b0;
      condResult  <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      rspValid    <= reqValid;
      writePermit <= isStore && (!reqLocked || condOk);
      condResult  <= condOk;
      overflow    <= dropLl;
    end
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CTX_W     = 4,
  parameter int ENTRIES   = 8,
  parameter int GRAN_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqRead,
  input  logic              reqWrite,
  input  logic              reqLocked,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CTX_W-1:0]  reqCtx,
  output logic              rspValid,
  output logic              writePermit,
  output logic              condResult,
  output logic              overflow
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  resvStrobes_t       strobes;
  logic [TAG_W-1:0]   reqTag;
  logic [ENTRIES-1:0] ctxHit, tagHit;
  logic               tableFull;
  logic               unusedLowBits;

  assign reqTag        = reqAddr[ADDR_W-1:GRAN_BITS];
  assign unusedLowBits = ^reqAddr[GRAN_BITS-1:0];

  resv_table #(.TAG_W(TAG_W), .CTX_W(CTX_W), .ENTRIES(ENTRIES)) uTable (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqTag(reqTag), .reqCtx(reqCtx),
    .ctxHit(ctxHit), .tagHit(tagHit), .tableFull(tableFull)
  );

  resv_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqWrite(reqWrite), .reqLocked(reqLocked), .ctxHit(ctxHit), .tagHit(tagHit),
    .tableFull(tableFull), .strobes(strobes), .rspValid(rspValid),
    .writePermit(writePermit), .condResult(condResult), .overflow(overflow)
  );
endmodule

// File: rtl/resv_monitor_checker.sv
module resv_monitor_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqRead,
  input logic reqWrite,
  input logic reqLocked,
  input logic rspValid,
  input logic writePermit,
  input logic condResult,
  input logic overflow
);
  logic started;
  always_ff @(posedge clk) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  // R11: every accepted request is answered on the next cycle
  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R11: a response only comes from a request
  assert_rsp_has_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    (started && rspValid) |-> $past(reqValid));

  // R8: a plain store is always permitted
  assert_plain_store_permit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqLocked) |=> (writePermit && !condResult));

  // R2: a write permit only follows a store request
  assert_permit_from_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    (started && writePermit) |-> $past(reqValid && reqWrite));

  // R9: a conditional success always carries the permit
  assert_cond_implies_permit_R9: assert property (@(posedge clk) disable iff (!rstN)
    condResult |-> writePermit);

  // R10: overflow only follows a load-locked request
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (started && overflow) |-> $past(reqValid && !reqWrite && reqRead && reqLocked));

  // R1: outputs are clear in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    (!rstN) |=> (!rspValid && !writePermit && !condResult && !overflow));
endmodule

bind resv_monitor resv_monitor_checker chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
  .reqWrite(reqWrite), .reqLocked(reqLocked), .rspValid(rspValid),
  .writePermit(writePermit), .condResult(condResult), .overflow(overflow)
);

// File: tb/resv_monitor_test.sv
`timescale 1ns/1ps
module resv_monitor_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqRead = 1'b0, reqWrite = 1'b0, reqLocked = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqCtx = '0;
  logic        rspValid, writePermit, condResult, overflow;
  int          checks = 0, errors = 0;
  logic        gotV, gotP, gotC, gotO;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  resv_monitor uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqWrite(reqWrite), .reqLocked(reqLocked), .reqAddr(reqAddr), .reqCtx(reqCtx),
    .rspValid(rspValid), .writePermit(writePermit), .condResult(condResult),
    .overflow(overflow)
  );

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  // Issue one request at a falling edge, capture the registered response
  // at the next falling edge.
  task automatic op(logic rd, logic wr, logic lk, logic [31:0] a, logic [3:0] c);
    reqValid = 1'b1; reqRead = rd; reqWrite = wr; reqLocked = lk;
    reqAddr = a; reqCtx = c;
    @(negedge clk);
    gotV = rspValid; gotP = writePermit; gotC = condResult; gotO = overflow;
    reqValid = 1'b0; reqRead = 1'b0; reqWrite = 1'b0; reqLocked = 1'b0;
  endtask

  task automatic loadLocked(logic [31:0] a, logic [3:0] c); op(1, 0, 1, a, c); endtask
  task automatic storeCond(logic [31:0] a, logic [3:0] c);  op(0, 1, 1, a, c); endtask
  task automatic storePlain(logic [31:0] a, logic [3:0] c); op(0, 1, 0, a, c); endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    check("R1 rspValid", rspValid, 0);
    check("R1 writePermit", writePermit, 0);
    check("R1 overflow", overflow, 0);
    storeCond(32'h40, 4'd0);
    check("R1 sc after reset fails", gotC, 0);
  endtask

  task automatic testBasic();
    doReset();
    loadLocked(32'h100, 4'd1);
    check("R11 ll rspValid", gotV, 1);
    check("R11 ll no permit", gotP, 0);
    storeCond(32'h100, 4'd1);
    check("R2 sc success result", gotC, 1);
    check("R2 sc success permit", gotP, 1);
    check("R11 sc rspValid", gotV, 1);
  endtask

  task automatic testGranule();
    doReset();
    loadLocked(32'h200, 4'd2);
    storeCond(32'h208, 4'd2);
    check("R3 next granule fails", gotC, 0);
    storeCond(32'h207, 4'd2);
    check("R3 same granule succeeds", gotC, 1);
  endtask

  task automatic testOtherCtx();
    doReset();
    loadLocked(32'h300, 4'd3);
    storeCond(32'h300, 4'd4);
    check("R4 other ctx sc fails", gotC, 0);
    check("R9 failed sc no permit", gotP, 0);
    storeCond(32'h300, 4'd3);
    check("R6 failed sc cleared entry", gotC, 0);
  endtask

  task automatic testPlainStore();
    doReset();
    loadLocked(32'h400, 4'd0);
    loadLocked(32'h404, 4'd1);
    storePlain(32'h403, 4'd2);
    check("R8 plain permit", gotP, 1);
    check("R8 plain no cond", gotC, 0);
    storeCond(32'h400, 4'd0);
    check("R5 ctx0 cleared by store", gotC, 0);
    storeCond(32'h400, 4'd1);
    check("R5 ctx1 cleared by store", gotC, 0);
  endtask

  task automatic testShared();
    doReset();
    loadLocked(32'h500, 4'd5);
    loadLocked(32'h500, 4'd6);
    loadLocked(32'h600, 4'd7);
    op(1, 0, 0, 32'h500, 4'd5);  // plain load
    check("R11 plain load rspValid", gotV, 1);
    check("R11 plain load no permit", gotP, 0);
    check("R11 plain load no overflow", gotO, 0);
    storeCond(32'h500, 4'd6);
    check("R12 shared sc succeeds", gotC, 1);
    storeCond(32'h500, 4'd5);
    check("R6 success sc cleared sibling", gotC, 0);
    storeCond(32'h600, 4'd7);
    check("R12 unrelated entry intact", gotC, 1);
  endtask

  task automatic testReplace();
    doReset();
    loadLocked(32'h700, 4'd0);
    loadLocked(32'h800, 4'd0);
    storeCond(32'h700, 4'd0);
    check("R7 old reservation gone", gotC, 0);
    storeCond(32'h800, 4'd0);
    check("R7 new reservation held", gotC, 1);
  endtask

  task automatic testFull();
    doReset();
    for (int i = 0; i < 8; i++) begin
      loadLocked(32'h1000 + 32'(i * 8), 4'(i));
      check("R10 fill no overflow", gotO, 0);
    end
    loadLocked(32'h2100, 4'd8);
    check("R10 overflow on full", gotO, 1);
    @(negedge clk);
    check("R10 overflow one cycle", overflow, 0);
    loadLocked(32'h2000, 4'd3);
    check("R10 update while full no overflow", gotO, 0);
    storeCond(32'h2100, 4'd8);
    check("R10 dropped ll has no entry", gotC, 0);
    storeCond(32'h2000, 4'd3);
    check("R10 moved entry succeeds", gotC, 1);
    loadLocked(32'h2100, 4'd8);
    check("R10 freed slot no overflow", gotO, 0);
    storeCond(32'h2100, 4'd8);
    check("R10 new entry succeeds", gotC, 1);
    storeCond(32'h1000, 4'd0);
    check("R10 original entry kept", gotC, 1);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testBasic();
    testGranule();
    testOtherCtx();
    testPlainStore();
    testShared();
    testReplace();
    testFull();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule